// File: doc/BRIEF.md
# Four-Slot Period Descriptor Queue

This block is the per-channel descriptor queue of a cyclic audio DMA engine. Software builds each transfer descriptor by writing four 32-bit words, one after another, to a single word port. The queue assembles them and holds up to four complete descriptors. On the other side, the transfer engine takes one whole descriptor each time it starts the next audio period. A status word shows where the producer and the consumer stand in the ring. A sticky error bit records a descriptor that arrived while all slots were occupied.

The word port is a valid/ready stream. `wr_ready` is high except while the ring-reset control bit is set. A word counts as taken on any cycle where `wr_valid` and `wr_ready` are both high. The port never stalls on a full ring. A fourth word that lands on a full ring is accepted and then discarded, and the error bit is raised. The consumer port is also valid/ready. `out_valid` is high whenever at least one descriptor is held. The head descriptor is presented on the output pins and is removed on a cycle with `out_valid && out_ready`. The consumer may hold `out_ready` low for any length of time, and the head stays stable while it does.

Control and status are plain pins. `ctl_we` loads the ring-reset bit from `ctl_wdata[0]`. `sts_we` with `sts_wdata[10]` set clears the error bit.

Top module: `period_desc_queue`

## Requirements
- R1: The ring holds at most 4 descriptors. After 4 commits with no pop, FULL is set and further commits do not change the indices.
- R2: The status word fields are: bits [1:0] write slot index (next slot to fill), bits [5:4] read slot index (head slot), bit 8 EMPTY, bit 9 FULL, bit 10 ERROR. All other bits read 0. After reset the status word is 0x100.
- R3: Whenever the write and read indices are equal, exactly one of FULL and EMPTY is set. When they differ, neither is set.
- R4: The words of a descriptor are taken in this order: address low, address high, length, flags. The consumer sees `out_addr` = {address high, address low}, `out_len` = length and `out_flags` = flags.
- R5: A descriptor is committed, and the write index advances, only on the cycle its fourth word is taken. After one, two or three words, the status and `out_valid` are unchanged.
- R6: When a fourth word is taken while FULL is set, that descriptor is dropped, the indices and the stored descriptors are unchanged, and ERROR becomes 1. ERROR stays 1 through later pushes and pops.
- R7: Writing the status with bit 10 set clears ERROR. A status write with bit 10 clear leaves ERROR as it was.
- R8: While the control ring-reset bit (`ctl_wdata[0]` written as 1) is set, `wr_ready` is 0, and one cycle later the status reads 0x100 (both indices 0, EMPTY, ERROR clear). Any partly assembled descriptor is discarded. After a write of 0 releases the reset, the next word taken is treated as an address-low word.
- R9: `out_valid` equals NOT EMPTY. Descriptors leave in the order they were committed. Each pop advances the read index by one, wrapping from 3 to 0.
- R10: `out_notify` equals bit 16 of the head descriptor's flags word.
- R11: A commit and a pop in the same cycle on a non-full ring both take effect. Both indices advance and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write data; bit 0 is ring reset |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 32 | Status write data; bit 10 set clears ERROR |
| ring_status | output | 32 | Indices, EMPTY, FULL and ERROR |
| wr_valid | input | 1 | Descriptor word valid |
| wr_ready | output | 1 | Word port ready (low during ring reset) |
| wr_word | input | 32 | Descriptor word |
| out_valid | output | 1 | Head descriptor available |
| out_ready | input | 1 | Consumer takes the head descriptor |
| out_addr | output | 64 | Head buffer address |
| out_len | output | 32 | Head length in bytes |
| out_flags | output | 32 | Head flags word |
| out_notify | output | 1 | Head requests a completion notification |

## Verification
The hardest state to reach is a ring reset that lands in the middle of a descriptor while ERROR is set and the ring is full. To get there, the stimulus fills the ring, overflows it with a fifth descriptor, and then sends two loose words before asserting reset. After reset is released, a fresh descriptor must come out with its words in their correct places, which shows that the word position was cleared. A second hard case is the fourth word arriving on the same edge as a pop. The bench drives both on one cycle and checks that both indices step while occupancy holds.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W    = 32;
  localparam int DESC_WDS  = 4;
  // word order within one descriptor (arrival order is behaviour)
  localparam int IX_ADDR_LO = 0;
  localparam int IX_ADDR_HI = 1;
  localparam int IX_LEN     = 2;
  localparam int IX_FLAGS   = 3;
  // status word layout
  localparam int ST_WP_LSB  = 0;
  localparam int ST_RP_LSB  = 4;
  localparam int ST_EMPTY   = 8;
  localparam int ST_FULL    = 9;
  localparam int ST_ERR     = 10;
  localparam int CTL_RST    = 0;
  localparam int NOTIFY_BIT = 16;
endpackage

// File: rtl/dring_assembler.sv
module dring_assembler #(
  parameter int WORDS = 4,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       fire,
  input  logic [W-1:0]               word,
  output logic                       last,
  output logic [WORDS-1:0][W-1:0]    desc
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CW-1:0] pos;

  assign last = fire && (pos == CW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  pos <= '0;
    else if (fire)      pos <= last ? '0 : pos + CW'(1);
  end

  // earlier words are held; the final word is passed straight through
  for (genvar i = 0; i < WORDS - 1; i++) begin : g_hold
    logic [W-1:0] h;
    always_ff @(posedge clk) begin
      if (!rst_n)                           h <= '0;
      else if (fire && pos == CW'(i))       h <= word;
    end
    assign desc[i] = h;
  end
  assign desc[WORDS-1] = word;
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl #(
  parameter int SLOTS = 4,
  localparam int IW   = $clog2(SLOTS),
  localparam int CNTW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          commit,
  input  logic          pop,
  input  logic          err_clr,
  output logic          accept,
  output logic          pop_fire,
  output logic [IW-1:0] wp,
  output logic [IW-1:0] rp,
  output logic          full,
  output logic          empty,
  output logic          err
);
  logic [CNTW-1:0] cnt;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] v);
    return (v == IW'(SLOTS - 1)) ? '0 : v + IW'(1);
  endfunction

  assign full     = (cnt == CNTW'(SLOTS));
  assign empty    = (cnt == '0);
  assign accept   = commit && !full;
  assign pop_fire = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (accept)   wp <= step(wp);
      if (pop_fire) rp <= step(rp);
      case ({accept, pop_fire})
        2'b10:   cnt <= cnt + CNTW'(1);
        2'b01:   cnt <= cnt - CNTW'(1);
        default: cnt <= cnt;
      endcase
      if (commit && full) err <= 1'b1;
      else if (err_clr)   err <= 1'b0;
    end
  end
endmodule

// File: rtl/dring_slots.sv
module dring_slots #(
  parameter int SLOTS = 4,
  parameter int DW    = 128,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [DW-1:0] s;
    always_ff @(posedge clk) begin
      if (!rst_n)                          s <= '0;
      else if (we && waddr == IW'(i))      s <= wdata;
    end
    assign cells[i] = s;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/period_desc_queue.sv
module period_desc_queue
  import dring_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int IW   = $clog2(SLOTS),
  localparam int DW   = DESC_WDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [WORD_W-1:0]   ctl_wdata,
  input  logic                sts_we,
  input  logic [WORD_W-1:0]   sts_wdata,
  output logic [WORD_W-1:0]   ring_status,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [WORD_W-1:0]   wr_word,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*WORD_W-1:0] out_addr,
  output logic [WORD_W-1:0]   out_len,
  output logic [WORD_W-1:0]   out_flags,
  output logic                out_notify
);
  logic ring_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)       ring_rst <= 1'b0;
    else if (ctl_we)  ring_rst <= ctl_wdata[CTL_RST];
  end

  logic in_fire, fire_last;
  logic [DESC_WDS-1:0][WORD_W-1:0] asm_desc;
  assign wr_ready = !ring_rst;
  assign in_fire  = wr_valid && wr_ready;

  dring_assembler #(.WORDS(DESC_WDS), .W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(ring_rst), .fire(in_fire),
    .word(wr_word), .last(fire_last), .desc(asm_desc)
  );

  logic          accept, pop_fire, full, empty, err;
  logic [IW-1:0] wp, rp;

  dring_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(ring_rst), .commit(fire_last),
    .pop(out_ready), .err_clr(sts_we && sts_wdata[ST_ERR]),
    .accept(accept), .pop_fire(pop_fire), .wp(wp), .rp(rp),
    .full(full), .empty(empty), .err(err)
  );

  logic [DW-1:0] head;
  logic [DESC_WDS-1:0][WORD_W-1:0] head_w;

  dring_slots #(.SLOTS(SLOTS), .DW(DW)) u_slots (
    .clk(clk), .rst_n(rst_n), .we(accept), .waddr(wp),
    .wdata(asm_desc), .raddr(rp), .rdata(head)
  );

  assign head_w     = head;
  assign out_valid  = !empty;
  assign out_addr   = {head_w[IX_ADDR_HI], head_w[IX_ADDR_LO]};
  assign out_len    = head_w[IX_LEN];
  assign out_flags  = head_w[IX_FLAGS];
  assign out_notify = head_w[IX_FLAGS][NOTIFY_BIT];

  always_comb begin
    ring_status                  = '0;
    ring_status[ST_WP_LSB +: IW] = wp;
    ring_status[ST_RP_LSB +: IW] = rp;
    ring_status[ST_EMPTY]        = empty;
    ring_status[ST_FULL]         = full;
    ring_status[ST_ERR]          = err;
  end
endmodule

// File: rtl/dring_checks.sv
module dring_checks #(
  parameter int SLOTS = 4,
  localparam int IW   = $clog2(SLOTS)
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ring_status,
  input logic        out_valid,
  input logic        out_ready,
  input logic        ring_rst,
  input logic        fire_last
);
  logic [IW-1:0] wpx, rpx;
  logic          emp, ful, erb;
  assign wpx = ring_status[dring_pkg::ST_WP_LSB +: IW];
  assign rpx = ring_status[dring_pkg::ST_RP_LSB +: IW];
  assign emp = ring_status[dring_pkg::ST_EMPTY];
  assign ful = ring_status[dring_pkg::ST_FULL];
  assign erb = ring_status[dring_pkg::ST_ERR];

  assert_one_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wpx == rpx) |-> ($countones({ful, emp}) == 1));

  assert_valid_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == !emp);

  assert_pop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !ring_rst) |=>
      (rpx == (($past(rpx) == IW'(SLOTS - 1)) ? '0 : $past(rpx) + IW'(1))));

  assert_overflow_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_last && ful && !ring_rst) |=> erb);

  assert_overflow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_last && ful && !out_ready && !ring_rst) |=> $stable(wpx) && ful);

  assert_partial_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_last && !ring_rst) |=> $stable(wpx));

  assert_reset_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_rst |=> (emp && !erb && wpx == '0 && rpx == '0));
endmodule

bind period_desc_queue dring_checks #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_status(ring_status),
  .out_valid(out_valid), .out_ready(out_ready),
  .ring_rst(ring_rst), .fire_last(fire_last)
);

// File: tb/period_desc_queue_test.sv
module period_desc_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, sts_we = 1'b0, wr_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] ctl_wdata = '0, sts_wdata = '0, wr_word = '0;
  logic [31:0] ring_status, out_len, out_flags;
  logic [63:0] out_addr;
  logic        wr_ready, out_valid, out_notify;

  period_desc_queue uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .ring_status(ring_status),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_word(wr_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_len(out_len), .out_flags(out_flags), .out_notify(out_notify)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // bench model of the ring
  int mwp = 0, mrp = 0, mcnt = 0, sn = 1;
  bit merr = 0;
  int exp_sn [4];

  function automatic logic [31:0] g_lo(int s);  return 32'h8000_0000 | (s << 6); endfunction
  function automatic logic [31:0] g_hi(int s);  return 32'h10 + s; endfunction
  function automatic logic [31:0] g_len(int s); return 32'h200 + s * 4; endfunction
  function automatic logic [31:0] g_fl(int s);  return ((s & 1) ? 32'h0001_0000 : 32'h0) | s; endfunction
  function automatic logic [31:0] m_status();
    return (32'(merr) << 10) | (32'(mcnt == 4) << 9) | (32'(mcnt == 0) << 8)
           | (32'(mrp) << 4) | 32'(mwp);
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_status(string req);
    check(req, "status", 64'(ring_status), 64'(m_status()));
    check(req, "out_valid", 64'(out_valid), 64'(mcnt != 0));
  endtask

  task automatic push_word(logic [31:0] w);
    wr_valid = 1'b1; wr_word = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic model_commit(int s);
    if (mcnt == 4) merr = 1;
    else begin exp_sn[mwp] = s; mwp = (mwp + 1) % 4; mcnt++; end
  endtask

  task automatic push_desc(string req);
    push_word(g_lo(sn)); push_word(g_hi(sn)); push_word(g_len(sn));
    push_word(g_fl(sn));
    model_commit(sn);
    sn++;
    chk_status(req);
  endtask

  task automatic chk_head(string req);
    int s = exp_sn[mrp];
    check(req, "addr", out_addr, {g_hi(s), g_lo(s)});
    check(req, "len", 64'(out_len), 64'(g_len(s)));
    check(req, "flags", 64'(out_flags), 64'(g_fl(s)));
    check("R10", "notify", 64'(out_notify), 64'(s & 1));
  endtask

  task automatic pop_chk(string req);
    chk_head(req);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    mrp = (mrp + 1) % 4; mcnt--;
    chk_status(req);
  endtask

  task automatic ring_reset(logic v);
    ctl_we = 1'b1; ctl_wdata = 32'(v);
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset status", 64'(ring_status), 64'h100);
    check("R8", "wr_ready idle", 64'(wr_ready), 64'd1);
    chk_status("R9");

    // R1/R4/R9 sweep over fill levels 1..4; indices wrap across rounds
    for (int fill = 1; fill <= 4; fill++) begin
      for (int k = 0; k < fill; k++) push_desc("R1");
      for (int k = 0; k < fill; k++) pop_chk("R9");
    end

    // R5: partial descriptor is invisible
    push_word(g_lo(sn));
    chk_status("R5");
    push_word(g_hi(sn));
    push_word(g_len(sn));
    chk_status("R5");
    push_word(g_fl(sn)); model_commit(sn); sn++;
    chk_status("R5");
    chk_head("R4");

    // R11: fourth word and pop on the same edge
    push_word(g_lo(sn)); push_word(g_hi(sn)); push_word(g_len(sn));
    chk_head("R11");
    wr_valid = 1'b1; wr_word = g_fl(sn); out_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; out_ready = 1'b0;
    model_commit(sn); sn++;
    mrp = (mrp + 1) % 4; mcnt--;
    chk_status("R11");
    chk_head("R11");
    pop_chk("R9");

    // R6: fill then overflow
    for (int k = 0; k < 4; k++) push_desc("R1");
    check("R3", "full flag", 64'(ring_status[9:8]), 64'h2);
    push_desc("R6");
    check("R6", "err bit", 64'(ring_status[10]), 64'd1);
    for (int k = 0; k < 4; k++) pop_chk("R6");
    check("R6", "err sticky", 64'(ring_status[10]), 64'd1);

    // R7: clear semantics
    sts_we = 1'b1; sts_wdata = 32'hFFFF_FBFF;
    @(negedge clk); sts_we = 1'b0;
    chk_status("R7");
    sts_we = 1'b1; sts_wdata = 32'h400;
    @(negedge clk); sts_we = 1'b0;
    merr = 0;
    chk_status("R7");

    // R8: reset while full, errored and mid-descriptor
    for (int k = 0; k < 5; k++) push_desc("R6");
    push_word(32'hDEAD_0001); push_word(32'hDEAD_0002);
    ring_reset(1'b1);
    check("R8", "wr_ready in reset", 64'(wr_ready), 64'd0);
    push_word(32'hDEAD_0003);
    mwp = 0; mrp = 0; mcnt = 0; merr = 0;
    check("R8", "status in reset", 64'(ring_status), 64'h100);
    ring_reset(1'b0);
    check("R8", "wr_ready released", 64'(wr_ready), 64'd1);
    push_desc("R8");
    pop_chk("R8");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule